// File: doc/BRIEF.md
# Control Register Bank with Default-State Detection

This block holds the control register image of a mixed-signal device behind a simple parallel write/read port. One control byte carries the mute bit, the active-standby and passive-standby selects and a write-only request bit. The request bit is used to clear the power-on indicator. Further control bytes hold ordinary settings. The block decodes the two standby bits into one operating mode. From that mode it drives the mute, the per-domain enables and a discharge enable for the output pins.

The power-on indicator is not a sticky flag. It is a live comparison of every stored bit against its power-on default, reduced by a single AND. The indicator therefore reads 1 after a real reset. It also reads 1 whenever software writes the defaults back. Software can prove that a reset has occurred by first setting the request bit. That bit defaults to 0, so setting it breaks the match.

An asynchronous power-on reset and a synchronous supply-dip reset both reload the defaults. Entering or leaving a standby mode never alters the stored image.

Top module: `ctl_reg_bank`

## Requirements
- R1: While the asynchronous reset is held and after it is released, every register holds its default. With the default configuration this means register 0 = 0x01 (bit 0 mute = 1) and registers 1..3 = 0xC3, 0x00, 0x5A. The power-on indicator reads 1, the mode is normal (2'b00) and mute is on.
- R2: A supply-dip reset pulse that is high at a rising clock edge reloads every register with its default at that edge. The indicator then reads 1.
- R3: The power-on indicator is 1 exactly when every stored bit of every register equals its default. This includes the case where software has rewritten the default values. A single differing bit in any register makes it 0.
- R4: Register 0 bit 3 is the clear request. Its default is 0. Once written to 1 it forces the indicator to 0, whatever the other bits hold. It always reads back as 0.
- R5: Register 0 bit 2 (passive) = 1 selects passive standby (mode 2'b10), whatever bit 1 holds. With bit 2 = 0 and bit 1 (active) = 1, the mode is active standby (2'b01). With both bits at 0, the mode is normal (2'b00).
- R6: The mute output is the OR of register 0 bit 0, the active-standby mode and the external auto-mute input.
- R7: The core enable is 1 only in normal mode. The output-path enable (output, line and decoder select) is 1 in normal and active standby and 0 in passive standby. The discharge enable is 1 only in passive standby.
- R8: Changing the mode between normal, active and passive standby leaves the contents of all other registers unchanged. Without a write or a reset, no stored bit changes.
- R9: The read port returns, combinationally, the stored byte at the read address (register 0 with bit 3 masked to 0).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous power-on reset, active low |
| dip_rst | input | 1 | Synchronous supply-dip reset, active high |
| wr_en | input | 1 | Write strobe |
| wr_addr | input | AW | Write register address |
| wr_data | input | DW | Write data |
| rd_addr | input | AW | Read register address |
| rd_data | output | DW | Read data |
| automute_in | input | 1 | External power-down auto-mute request |
| mode_o | output | 2 | Operating mode: 00 normal, 01 active standby, 10 passive standby |
| mute_o | output | 1 | Effective mute |
| core_en | output | 1 | Core circuits enable |
| path_en | output | 1 | Output, line and decoder path enable |
| discharge_en | output | 1 | Output pin discharge enable |
| por_flag | output | 1 | Power-on indicator (image equals defaults) |

## Verification
The bench sweeps all sixteen values of the low nibble of register 0, once with auto-mute low and once with it high. This separates the passive-over-active priority, the three mute sources and the effect of the clear request on the indicator. It then flips each bit of every other register one at a time and restores it. This shows that the indicator covers every bit position and recovers on a software rewrite of the defaults. Finally it walks the modes with non-default settings stored and applies a supply-dip reset. Together these distinguish mode changes, which preserve data, from resets, which restore defaults.

// File: rtl/ctl_reg_pkg.sv
package ctl_reg_pkg;
   typedef enum logic [1:0] {
      MODE_NORMAL  = 2'b00,
      MODE_ACTIVE  = 2'b01,
      MODE_PASSIVE = 2'b10
   } ctl_mode_e;

   // bit positions inside control register 0 (decoded by the mode logic)
   localparam int unsigned MUTE_POS  = 0;
   localparam int unsigned ACT_POS   = 1;
   localparam int unsigned PAS_POS   = 2;
   localparam int unsigned CLR_POS   = 3;
endpackage

// File: rtl/ctl_reg_file.sv
module ctl_reg_file #(
   parameter int unsigned NREG     = 4,
   parameter int unsigned DW       = 8,
   parameter int unsigned AW       = 2,
   parameter logic [NREG*DW-1:0] DEFAULTS = '0,
   parameter int unsigned HIDE_POS = 3,
   parameter bit          HIDE_EN  = 1'b1
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic                     dip_rst,
   input  logic                     wr_en,
   input  logic [AW-1:0]            wr_addr,
   input  logic [DW-1:0]            wr_data,
   input  logic [AW-1:0]            rd_addr,
   output logic [DW-1:0]            rd_data,
   output logic [NREG-1:0][DW-1:0]  img
);
   localparam logic [DW-1:0] HIDE_MASK = {{(DW-1){1'b0}}, 1'b1} << HIDE_POS;

   logic [DW-1:0] raw;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)          img <= DEFAULTS;
      else if (dip_rst)    img <= DEFAULTS;
      else if (wr_en)      img[wr_addr] <= wr_data;
   end

   assign raw = img[rd_addr];

   generate
      if (HIDE_EN) begin : g_hide
         assign rd_data = (rd_addr == AW'(0)) ? (raw & ~HIDE_MASK) : raw;
      end else begin : g_plain
         assign rd_data = raw;
      end
   endgenerate

   AST_IMG_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (!wr_en && !dip_rst) |=> $stable(img)); // R8
   AST_DIP_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
      dip_rst |=> (img == DEFAULTS)); // R2
endmodule

// File: rtl/ctl_dflt_cmp.sv
module ctl_dflt_cmp #(
   parameter int unsigned NBITS = 32,
   parameter logic [NBITS-1:0] DEFAULTS = '0
) (
   input  logic [NBITS-1:0] flat,
   output logic             match
);
   logic [NBITS-1:0] eq;

   generate
      for (genvar i = 0; i < NBITS; i++) begin : g_bit
         assign eq[i] = ~(flat[i] ^ DEFAULTS[i]);
      end
   endgenerate

   assign match = &eq;
endmodule

// File: rtl/ctl_mode_dec.sv
module ctl_mode_dec
   import ctl_reg_pkg::*;
(
   input  logic      clk,
   input  logic      rst_n,
   input  logic      mute_bit,
   input  logic      act_bit,
   input  logic      pas_bit,
   input  logic      automute_in,
   output ctl_mode_e mode,
   output logic      mute_o,
   output logic      core_en,
   output logic      path_en,
   output logic      discharge_en
);
   always_comb begin
      if (pas_bit)      mode = MODE_PASSIVE;
      else if (act_bit) mode = MODE_ACTIVE;
      else              mode = MODE_NORMAL;
   end

   assign mute_o       = mute_bit | (mode == MODE_ACTIVE) | automute_in;
   assign core_en      = (mode == MODE_NORMAL);
   assign path_en      = (mode != MODE_PASSIVE);
   assign discharge_en = (mode == MODE_PASSIVE);

   AST_PASSIVE_WINS: assert property (@(posedge clk) disable iff (!rst_n)
      pas_bit |-> (mode == MODE_PASSIVE)); // R5
   AST_ACTIVE_MUTES: assert property (@(posedge clk) disable iff (!rst_n)
      (mode == MODE_ACTIVE) |-> mute_o); // R6
   AST_DISCH_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
      discharge_en |-> (!core_en && !path_en)); // R7
endmodule

// File: rtl/ctl_reg_bank.sv
module ctl_reg_bank
   import ctl_reg_pkg::*;
#(
   parameter int unsigned NREG = 4,
   parameter int unsigned DW   = 8,
   parameter int unsigned AW   = (NREG > 1) ? $clog2(NREG) : 1,
   parameter logic [NREG*DW-1:0] DEFAULTS = 32'h5A_00_C3_01,
   parameter bit          HIDE_CLR = 1'b1
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          dip_rst,
   input  logic          wr_en,
   input  logic [AW-1:0] wr_addr,
   input  logic [DW-1:0] wr_data,
   input  logic [AW-1:0] rd_addr,
   output logic [DW-1:0] rd_data,
   input  logic          automute_in,
   output logic [1:0]    mode_o,
   output logic          mute_o,
   output logic          core_en,
   output logic          path_en,
   output logic          discharge_en,
   output logic          por_flag
);
   localparam int unsigned NBITS = NREG * DW;

   generate
      if (DW <= CLR_POS) begin : g_bad_width
         $error("ctl_reg_bank: DW must hold the control bits");
      end
      if ((1 << AW) != NREG) begin : g_bad_depth
         $error("ctl_reg_bank: NREG must equal 2**AW");
      end
      if (DEFAULTS[CLR_POS] != 1'b0) begin : g_bad_clr
         $error("ctl_reg_bank: clear request default must be 0");
      end
   endgenerate

   logic [NREG-1:0][DW-1:0] img;
   ctl_mode_e               mode;

   ctl_reg_file #(
      .NREG(NREG), .DW(DW), .AW(AW), .DEFAULTS(DEFAULTS),
      .HIDE_POS(CLR_POS), .HIDE_EN(HIDE_CLR)
   ) u_file (
      .clk(clk), .rst_n(rst_n), .dip_rst(dip_rst),
      .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
      .rd_addr(rd_addr), .rd_data(rd_data), .img(img)
   );

   ctl_dflt_cmp #(.NBITS(NBITS), .DEFAULTS(DEFAULTS)) u_cmp (
      .flat(img), .match(por_flag)
   );

   ctl_mode_dec u_dec (
      .clk(clk), .rst_n(rst_n),
      .mute_bit(img[0][MUTE_POS]), .act_bit(img[0][ACT_POS]),
      .pas_bit(img[0][PAS_POS]), .automute_in(automute_in),
      .mode(mode), .mute_o(mute_o), .core_en(core_en),
      .path_en(path_en), .discharge_en(discharge_en)
   );

   assign mode_o = mode;

   AST_CLR_BREAKS: assert property (@(posedge clk) disable iff (!rst_n)
      img[0][CLR_POS] |-> !por_flag); // R4
   AST_DIP_MATCH: assert property (@(posedge clk) disable iff (!rst_n)
      dip_rst |=> por_flag); // R2
   AST_MODE_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(mode_o)); // R5
endmodule

// File: tb/ctl_reg_bank_bench.sv
module ctl_reg_bank_bench;
   localparam logic [7:0] D0 = 8'h01, D1 = 8'hC3, D2 = 8'h00, D3 = 8'h5A;

   logic       clk = 1'b0, rst_n = 1'b0, dip_rst = 1'b0, wr_en = 1'b0;
   logic [1:0] wr_addr = '0, rd_addr = '0;
   logic [7:0] wr_data = '0;
   logic       automute_in = 1'b0;
   logic [7:0] rd_data;
   logic [1:0] mode_o;
   logic       mute_o, core_en, path_en, discharge_en, por_flag;
   int         n_run = 0, n_fail = 0;
   logic [7:0] dflt [4];

   always #5 clk = ~clk;

   ctl_reg_bank u_ctl_reg_bank (
      .clk(clk), .rst_n(rst_n), .dip_rst(dip_rst), .wr_en(wr_en),
      .wr_addr(wr_addr), .wr_data(wr_data), .rd_addr(rd_addr),
      .rd_data(rd_data), .automute_in(automute_in), .mode_o(mode_o),
      .mute_o(mute_o), .core_en(core_en), .path_en(path_en),
      .discharge_en(discharge_en), .por_flag(por_flag)
   );

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      n_run++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: actual %0h expected %0h", req, act, exp);
      end
   endtask

   task automatic wr(input logic [1:0] a, input logic [7:0] d);
      wr_en = 1'b1; wr_addr = a; wr_data = d;
      @(negedge clk);
      wr_en = 1'b0;
   endtask

   task automatic rd(input logic [1:0] a, output logic [7:0] d);
      rd_addr = a; #1; d = rd_data;
   endtask

   initial begin
      #2_000_000;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end

   initial begin
      logic [7:0] r;
      dflt[0] = D0; dflt[1] = D1; dflt[2] = D2; dflt[3] = D3;
      repeat (3) @(negedge clk);
      // R1: state during reset
      chk("R1 por in reset", por_flag, 1);
      rst_n = 1'b1;
      @(negedge clk);
      chk("R1 por", por_flag, 1);
      chk("R1 mode", mode_o, 0);
      chk("R1 mute", mute_o, 1);
      for (int i = 0; i < 4; i++) begin
         rd(2'(i), r);
         chk("R1 R9 default readback", r, dflt[i]);
      end

      // R5 R6 R7 R4 R3: sweep low nibble of register 0 with auto-mute low and high
      for (int am = 0; am < 2; am++) begin
         automute_in = am[0];
         for (int v = 0; v < 16; v++) begin
            logic [1:0] em;
            wr(2'd0, 8'(v));
            em = v[2] ? 2'b10 : (v[1] ? 2'b01 : 2'b00);
            chk("R5 mode", mode_o, em);
            chk("R6 mute", mute_o, v[0] | (em == 2'b01) | am[0]);
            chk("R7 core_en", core_en, em == 2'b00);
            chk("R7 path_en", path_en, em != 2'b10);
            chk("R7 discharge_en", discharge_en, em == 2'b10);
            chk("R3 R4 por", por_flag, v == 1);
            rd(2'd0, r);
            chk("R4 R9 reg0 readback", r, 8'(v) & 8'hF7);
         end
      end
      automute_in = 1'b0;
      wr(2'd0, D0);
      chk("R3 rewrite default", por_flag, 1);

      // R3: each bit of each other register breaks the match; rewrite restores it
      for (int i = 1; i < 4; i++) begin
         for (int b = 0; b < 8; b++) begin
            wr(2'(i), dflt[i] ^ (8'h1 << b));
            chk("R3 single bit differs", por_flag, 0);
            wr(2'(i), dflt[i]);
            chk("R3 restored by write", por_flag, 1);
         end
      end
      // R4: upper bits of reg0 also count, clear bit forces 0
      wr(2'd0, 8'h81);
      chk("R3 reg0 upper bit", por_flag, 0);
      wr(2'd0, 8'h09);
      chk("R4 clear forces 0", por_flag, 0);
      chk("R4 mute kept", mute_o, 1);

      // R8: mode walk preserves other registers
      wr(2'd1, 8'h3C); wr(2'd2, 8'hA5); wr(2'd3, 8'h7E);
      wr(2'd0, 8'h04); wr(2'd0, 8'h02); wr(2'd0, 8'h06); wr(2'd0, 8'h00);
      rd(2'd1, r); chk("R8 reg1 kept", r, 8'h3C);
      rd(2'd2, r); chk("R8 reg2 kept", r, 8'hA5);
      rd(2'd3, r); chk("R8 reg3 kept", r, 8'h7E);
      chk("R8 mode normal", mode_o, 0);
      repeat (3) @(negedge clk);
      rd(2'd2, r); chk("R8 idle hold", r, 8'hA5);

      // R2: supply-dip reset
      wr(2'd0, 8'h0E);
      dip_rst = 1'b1; @(negedge clk); dip_rst = 1'b0;
      chk("R2 por", por_flag, 1);
      chk("R2 mute", mute_o, 1);
      chk("R2 mode", mode_o, 0);
      for (int i = 0; i < 4; i++) begin
         rd(2'(i), r);
         chk("R2 default readback", r, dflt[i]);
      end

      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end
endmodule